// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Block

This block collects single-cycle event pulses from up to 32 hardware sources into a cause register and raises one level interrupt. The interrupt is the OR of every pending cause that is not masked. Software reaches the block through a simple 32-bit register port: an address, a write strobe with write data, and a read strobe. Read data comes back one cycle after the read strobe.

Every source has its own bit, and that bit has the same position in all seven registers. A per-source control bit chooses how that source's cause bit is cleared. In one mode a 1 written to the bit clears it. In the other mode a read clears the bit, but only if it returned as 1. Software can also inject a cause by writing to a set alias. It can change single mask bits through separate set and clear aliases, so it never needs a read-modify-write. A masked view of the cause register shows only the pending causes that are not masked.

The block is built from these parts: an address decoder, a generated row of per-source cause cells, and a mask bank. A registered read mux and a registered interrupt output sit on top of them.

Top module: `irq_cause_regs`

## Requirements
- R1: After reset, the cause and clear-mode registers are 0, every mask bit that belongs to a source is 1, irq_out is low and reg_rdata is 0.
- R2: Register map, by byte address. 0x00 is clear-mode (read/write). 0x04 is cause. 0x08 is masked cause. 0x0C is cause-set (write-only). 0x10 is mask (read/write). 0x14 is mask-set (write-only). 0x18 is mask-clear (write-only). Bit i stands for source i in every register. reg_rdata shows the addressed value in the cycle after reg_re is high, and is 0 in a cycle that follows no read. Bits at or above NSRC read as 0.
- R3: A 1 on hw_event[i] sets cause bit i at the next clock edge.
- R4: A source whose clear-mode bit is 0 clears its cause bit when a 1 is written to that bit at either the cause address or the masked-cause address. A 0 written leaves the bit unchanged, and a read does not change it.
- R5: A source whose clear-mode bit is 1 clears its cause bit when a read returns that bit as 1. A read of the cause address returns all pending bits. A read of the masked-cause address returns only the unmasked ones. Writing a 1 to the bit at the cause address has no effect in this mode.
- R6: An event on a source in the same cycle as a clear of that source's bit, by write or by read, leaves the cause bit set.
- R7: A 1 written to a bit of cause-set sets that cause bit. A 0 written has no effect.
- R8: A read of the masked-cause address returns cause AND NOT mask.
- R9: A write to the mask address loads the mask. A 1 written to a bit of mask-set sets that mask bit. A 1 written to a bit of mask-clear clears it. All other mask bits are kept.
- R10: irq_out is registered, and at every clock it equals the OR of cause AND NOT mask as held in the registers at that moment.
- R11: Reads of the write-only addresses, of unmapped addresses and of unaligned addresses return 0. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_re | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_re |
| hw_event | input | NSRC | Per-source event pulses |
| irq_out | output | 1 | Level interrupt: any unmasked pending cause |

## Verification
The bench uses eight sources.

- **Masked view and interrupt.** It steps through all 256 cause patterns, each paired with a different mask derived arithmetically from it. For each pair it compares the masked view and the interrupt level. This tells a correct AND-NOT apart from a plain cause read or a plain mask read.
- **Events.** It fires each source's event alone in clear-on-read mode. This separates errors in bit position from errors in clearing.
- **Mixed clear modes.** It splits the clear-mode bits between the two modes and reads through both the cause view and the masked view. This shows whether a read clears exactly the returned bits of the sources in clear-on-read mode.
- **Collisions.** It drives events in the same cycle as write clears and as read clears. This shows whether an event survives a clear.
- **Write-only and unmapped addresses.** It reads and writes these addresses and then reads the live registers back. This confirms that nothing leaks out and nothing is changed.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

   // Number of mapped 32-bit words in the block.
   localparam int unsigned REG_COUNT = 7;

   // Register selector; the value times four is the byte offset.
   typedef enum logic [2:0] {
      SEL_CTRL   = 3'd0,
      SEL_CAUSE  = 3'd1,
      SEL_MCAUSE = 3'd2,
      SEL_CSET   = 3'd3,
      SEL_MASK   = 3'd4,
      SEL_MSET   = 3'd5,
      SEL_MCLR   = 3'd6,
      SEL_NONE   = 3'd7
   } reg_sel_e;

   // Qualified access strobes produced by the decoder.
   typedef struct packed {
      logic ctrl_wr;
      logic cause_w1c;
      logic cset_wr;
      logic mask_wr;
      logic mset_wr;
      logic mclr_wr;
      logic cause_rd;
      logic mcause_rd;
   } strobe_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   output strobe_t           stb,
   output reg_sel_e          rd_sel
);

   localparam int unsigned WORD_W = ADDR_W - 2;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("irq_reg_decode: ADDR_W must be at least 5");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              aligned;
   logic              in_range;
   reg_sel_e          sel;

   always_comb begin
      word     = addr[ADDR_W-1:2];
      aligned  = (addr[1:0] == 2'b00);
      in_range = (word < WORD_W'(REG_COUNT));
      sel      = (aligned && in_range) ? reg_sel_e'(word[2:0]) : SEL_NONE;
   end

   always_comb begin
      stb.ctrl_wr   = we && (sel == SEL_CTRL);
      stb.cause_w1c = we && ((sel == SEL_CAUSE) || (sel == SEL_MCAUSE));
      stb.cset_wr   = we && (sel == SEL_CSET);
      stb.mask_wr   = we && (sel == SEL_MASK);
      stb.mset_wr   = we && (sel == SEL_MSET);
      stb.mclr_wr   = we && (sel == SEL_MCLR);
      stb.cause_rd  = re && (sel == SEL_CAUSE);
      stb.mcause_rd = re && (sel == SEL_MCAUSE);
      rd_sel        = re ? sel : SEL_NONE;
   end

endmodule

// File: rtl/irq_cause_cell.sv
module irq_cause_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic w1c_stb,
   input  logic set_stb,
   input  logic wbit,
   input  logic cause_rd,
   input  logic mcause_rd,
   input  logic mask_bit,
   input  logic hw_ev,
   output logic cause_q,
   output logic ctrl_q,
   output logic cause_d
);

   logic clr_w1c;
   logic rd_bit;
   logic clr_cor;
   logic set_bit;

   always_comb begin
      clr_w1c = w1c_stb & wbit & ~ctrl_q;
      rd_bit  = (cause_rd & cause_q) | (mcause_rd & cause_q & ~mask_bit);
      clr_cor = rd_bit & ctrl_q;
      set_bit = set_stb & wbit;
      // Events and injections are applied after the clear, so they win.
      cause_d = (cause_q & ~(clr_w1c | clr_cor)) | set_bit | hw_ev;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= 1'b0;
         ctrl_q  <= 1'b0;
      end else begin
         cause_q <= cause_d;
         if (ctrl_wr) ctrl_q <= wbit;
      end
   end

   // R3: an event always shows up in the cause bit.
   a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hw_ev |=> cause_q);

   // R6: an event that collides with a clear keeps the bit set.
   a_r6_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_ev && (clr_w1c || clr_cor)) |=> cause_q);

   // R5: a clear-on-read bit returned by a read is gone afterwards.
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_bit && ctrl_q && !hw_ev && !set_bit) |=> !cause_q);

   // R4: a read leaves a write-one-to-clear bit alone.
   a_r4_read_keeps_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_rd || mcause_rd) && !ctrl_q && !w1c_stb && !set_stb && !hw_ev)
      |=> $stable(cause_q));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mask_wr,
   input  logic            mset_wr,
   input  logic            mclr_wr,
   input  logic [NSRC-1:0] wdata,
   output logic [NSRC-1:0] mask_q,
   output logic [NSRC-1:0] mask_d
);

   localparam logic [NSRC-1:0] MASK_RESET = {NSRC{1'b1}};

   always_comb begin
      mask_d = mask_q;
      if (mask_wr) begin
         mask_d = wdata;
      end else begin
         if (mset_wr) mask_d = mask_d | wdata;
         if (mclr_wr) mask_d = mask_d & ~wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= MASK_RESET;
      else        mask_q <= mask_d;
   end

   // R9: mask-set raises every written bit.
   a_r9_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
      mset_wr |=> ((mask_q & $past(wdata)) == $past(wdata)));

   // R9: mask-clear drops every written bit.
   a_r9_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
      mclr_wr |=> ((mask_q & $past(wdata)) == '0));

   // R9: a mask-set or mask-clear write keeps the bits it does not name.
   a_r9_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ((mset_wr || mclr_wr) && !mask_wr)
      |=> ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));

endmodule

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
   import irq_regs_pkg::*;
#(
   parameter int unsigned NSRC   = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_re,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NSRC-1:0]   hw_event,
   output logic              irq_out
);

   localparam int unsigned PAD_W = (DATA_W > NSRC) ? DATA_W - NSRC : 1;

   generate
      if (NSRC < 1 || NSRC > DATA_W) begin : g_bad_nsrc
         $error("irq_cause_regs: NSRC must be in 1..DATA_W");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("irq_cause_regs: DATA_W must be 32");
      end
   endgenerate

   strobe_t           stb;
   reg_sel_e          rd_sel;
   logic [NSRC-1:0]   wdata_n;
   logic [NSRC-1:0]   cause_v;
   logic [NSRC-1:0]   cause_d_v;
   logic [NSRC-1:0]   ctrl_v;
   logic [NSRC-1:0]   mask_v;
   logic [NSRC-1:0]   mask_d_v;
   logic [NSRC-1:0]   rd_val;
   logic [DATA_W-1:0] rd_ext;
   logic [DATA_W-1:0] rdata_q;
   logic              irq_q;

   assign wdata_n = reg_wdata[NSRC-1:0];

   irq_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr   (reg_addr),
      .we     (reg_we),
      .re     (reg_re),
      .stb    (stb),
      .rd_sel (rd_sel)
   );

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_cell
         irq_cause_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_wr   (stb.ctrl_wr),
            .w1c_stb   (stb.cause_w1c),
            .set_stb   (stb.cset_wr),
            .wbit      (wdata_n[i]),
            .cause_rd  (stb.cause_rd),
            .mcause_rd (stb.mcause_rd),
            .mask_bit  (mask_v[i]),
            .hw_ev     (hw_event[i]),
            .cause_q   (cause_v[i]),
            .ctrl_q    (ctrl_v[i]),
            .cause_d   (cause_d_v[i])
         );
      end
   endgenerate

   irq_mask_bank #(.NSRC(NSRC)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_wr (stb.mask_wr),
      .mset_wr (stb.mset_wr),
      .mclr_wr (stb.mclr_wr),
      .wdata   (wdata_n),
      .mask_q  (mask_v),
      .mask_d  (mask_d_v)
   );

   always_comb begin
      unique case (rd_sel)
         SEL_CTRL:   rd_val = ctrl_v;
         SEL_CAUSE:  rd_val = cause_v;
         SEL_MCAUSE: rd_val = cause_v & ~mask_v;
         SEL_MASK:   rd_val = mask_v;
         default:    rd_val = '0;
      endcase
   end

   generate
      if (DATA_W > NSRC) begin : g_pad
         assign rd_ext = {{PAD_W{1'b0}}, rd_val};
      end else begin : g_full
         assign rd_ext = rd_val;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         rdata_q <= rd_ext;
         irq_q   <= |(cause_d_v & ~mask_d_v);
      end
   end

   assign reg_rdata = rdata_q;
   assign irq_out   = irq_q;

   // R10: the interrupt level matches the stored unmasked causes.
   a_r10_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == |(cause_v & ~mask_v));

   // R8: the masked view returns cause with the masked bits removed.
   a_r8_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
      stb.mcause_rd |=> (reg_rdata[NSRC-1:0] == $past(cause_v & ~mask_v)));

   // R11: write-only and unmapped reads return zero.
   a_r11_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re && (rd_sel inside {SEL_CSET, SEL_MSET, SEL_MCLR, SEL_NONE}))
      |=> (reg_rdata == '0));

   // R2: without a read the data port returns zero.
   a_r2_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_re |=> (reg_rdata == '0));

endmodule

// File: tb/irq_cause_regs_bench.sv
module irq_cause_regs_bench;

   localparam int unsigned NS = 8;
   localparam logic [7:0] A_CTRL   = 8'h00;
   localparam logic [7:0] A_CAUSE  = 8'h04;
   localparam logic [7:0] A_MCAUSE = 8'h08;
   localparam logic [7:0] A_CSET   = 8'h0C;
   localparam logic [7:0] A_MASK   = 8'h10;
   localparam logic [7:0] A_MSET   = 8'h14;
   localparam logic [7:0] A_MCLR   = 8'h18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic          reg_we = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic          reg_re = 1'b0;
   logic [31:0]   reg_rdata;
   logic [NS-1:0] hw_event = '0;
   logic          irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_cause_regs #(.NSRC(NS), .DATA_W(32), .ADDR_W(8)) u_irq_cause_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata),
      .hw_event  (hw_event),
      .irq_out   (irq_out)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_re = 1'b1;
      @(negedge clk);
      reg_re = 1'b0;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [NS-1:0] ev);
      @(negedge clk);
      hw_event = ev;
      @(negedge clk);
      hw_event = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R1..R11 got=hung exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 irq", {31'd0, irq_out}, 32'd0);
      chk("R1 rdata", reg_rdata, 32'd0);
      rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
      rd(A_CAUSE, d); chk("R1 cause", d, 32'h0);
      rd(A_MASK, d);  chk("R1 mask", d, 32'hFF);

      // R2: read/write of control, upper bits read zero, idle rdata zero
      wr(A_CTRL, 32'hA5);
      chk("R2 idle rdata", reg_rdata, 32'd0);
      rd(A_CTRL, d); chk("R2 ctrl rw", d, 32'hA5);
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, d); chk("R2 upper zero", d, 32'hFF);
      wr(A_CTRL, 32'h0);

      // R9: mask write, set and clear aliases
      wr(A_MASK, 32'h0F);
      rd(A_MASK, d); chk("R9 mask write", d, 32'h0F);
      wr(A_MSET, 32'h30);
      rd(A_MASK, d); chk("R9 mask set", d, 32'h3F);
      wr(A_MCLR, 32'h05);
      rd(A_MASK, d); chk("R9 mask clear", d, 32'h3A);

      // R11: write-only and unmapped reads, unmapped writes
      rd(A_MSET, d);  chk("R11 mset read", d, 32'h0);
      rd(A_MCLR, d);  chk("R11 mclr read", d, 32'h0);
      rd(A_CSET, d);  chk("R11 cset read", d, 32'h0);
      rd(8'h1C, d);   chk("R11 unmapped read", d, 32'h0);
      rd(8'h11, d);   chk("R11 unaligned read", d, 32'h0);
      wr(8'h1C, 32'hFF);
      wr(8'h20, 32'hFF);
      wr(8'h0D, 32'hFF);
      rd(A_MASK, d);  chk("R11 mask untouched", d, 32'h3A);
      rd(A_CTRL, d);  chk("R11 ctrl untouched", d, 32'h0);
      rd(A_CAUSE, d); chk("R11 cause untouched", d, 32'h0);

      // R3 / R10 / R4: event latching in write-one-to-clear mode
      wr(A_MASK, 32'h0);
      pulse(8'h05);
      chk("R10 irq on event", {31'd0, irq_out}, 32'd1);
      rd(A_CAUSE, d); chk("R3 event latched", d, 32'h05);
      rd(A_CAUSE, d); chk("R4 read keeps w1c", d, 32'h05);
      wr(A_CAUSE, 32'h04);
      rd(A_CAUSE, d); chk("R4 w1c clear", d, 32'h01);
      wr(A_MCAUSE, 32'h01);
      rd(A_CAUSE, d); chk("R4 w1c via masked", d, 32'h00);
      chk("R10 irq low", {31'd0, irq_out}, 32'd0);

      // R7: cause injection
      wr(A_CSET, 32'h81);
      chk("R7 irq", {31'd0, irq_out}, 32'd1);
      wr(A_CSET, 32'h00);
      rd(A_CAUSE, d); chk("R7 cause set", d, 32'h81);

      // R5: clear-on-read, writes ignored
      wr(A_CTRL, 32'hFF);
      wr(A_CAUSE, 32'h81);
      rd(A_CAUSE, d); chk("R5 w1c ignored", d, 32'h81);
      rd(A_CAUSE, d); chk("R5 read cleared", d, 32'h00);
      chk("R5 irq after cor", {31'd0, irq_out}, 32'd0);

      // R5 / R8: mixed modes through the masked view
      wr(A_CTRL, 32'hF0);
      wr(A_MASK, 32'h30);
      wr(A_CSET, 32'hFF);
      rd(A_MCAUSE, d); chk("R8 masked view", d, 32'hCF);
      rd(A_CAUSE, d);  chk("R5 masked read clears returned", d, 32'h3F);
      rd(A_CAUSE, d);  chk("R5 only cor bits cleared", d, 32'h0F);
      wr(A_CAUSE, 32'h0F);
      rd(A_CAUSE, d);  chk("R4 mixed w1c", d, 32'h00);

      // R6: event colliding with a write clear
      wr(A_CTRL, 32'h00);
      wr(A_MASK, 32'h00);
      wr(A_CSET, 32'h02);
      @(negedge clk);
      reg_addr = A_CAUSE; reg_wdata = 32'h02; reg_we = 1'b1; hw_event = 8'h02;
      @(negedge clk);
      reg_we = 1'b0; hw_event = '0;
      rd(A_CAUSE, d); chk("R6 event beats w1c", d, 32'h02);
      wr(A_CAUSE, 32'h02);

      // R6: event colliding with a clear-on-read
      wr(A_CTRL, 32'h02);
      wr(A_CSET, 32'h02);
      @(negedge clk);
      reg_addr = A_CAUSE; reg_re = 1'b1; hw_event = 8'h02;
      @(negedge clk);
      reg_re = 1'b0; hw_event = '0;
      chk("R6 read data", reg_rdata, 32'h02);
      rd(A_CAUSE, d); chk("R6 event beats cor", d, 32'h02);
      rd(A_CAUSE, d); chk("R6 later read clears", d, 32'h00);

      // R3: each source alone, clear-on-read mode
      wr(A_CTRL, 32'hFF);
      for (int i = 0; i < NS; i++) begin
         pulse(NS'(1) << i);
         chk("R3 irq per source", {31'd0, irq_out}, 32'd1);
         rd(A_CAUSE, d); chk("R3 source bit", d, 32'd1 << i);
         chk("R10 irq drops", {31'd0, irq_out}, 32'd0);
      end

      // R8 / R10: sweep of all cause patterns
      wr(A_CTRL, 32'h00);
      for (int c = 0; c < 256; c++) begin
         logic [7:0] m;
         logic [7:0] v;
         m = 8'((c * 29 + 7) & 255);
         v = 8'(c) & ~m;
         wr(A_MASK, {24'd0, m});
         wr(A_CSET, c);
         chk("R10 irq sweep", {31'd0, irq_out}, {31'd0, (v != 8'd0)});
         rd(A_MCAUSE, d); chk("R8 sweep", d, {24'd0, v});
         rd(A_CAUSE, d);  chk("R7 sweep", d, c);
         wr(A_CAUSE, 32'hFF);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule